// File: doc/BRIEF.md
# Disciplined Oscillator DAC Steering Controller

This block steers the tuning word of a local oscillator so that it stays on frequency against an external once-per-second reference pulse. It counts oscillator clock cycles between consecutive reference edges. Each count is compared with a nominal value and reduced to a single sign: plus (oscillator fast), minus (oscillator slow) or zero. A staged state machine decides from these signs when to move a 14-bit DAC tuning word by one step. The DAC word drives an external DAC and loop filter.

The controller moves through three stages. STG_WARMUP holds the DAC at mid-scale for a set number of samples. In STG_UNLOCKED the basic machine steps the DAC. STG_LOCKED is entered after a quiet period with no DAC change. The basic machine has the states BS_IDLE, BS_PLUS1 and BS_MINUS1. It steps the DAC when two same-sign errors arrive in a row, and zero seconds do not count. Once the loop is locked and has moved the DAC both up and down at some point, the refined machine takes over for good. Its states are RS_IDLE, RS_PLUS1, RS_MINUS1, RS_HOLD_DN and RS_HOLD_UP. A same-sign pair only arms a pending step. The sample that follows can veto that step with an opposite sign, which rejects the sawtooth jitter of the reference pulse. If the reference pulse goes missing, the block flags holdover and clears all pending decisions.

Transitions: STG_WARMUP→STG_UNLOCKED after the last warm-up sample; STG_UNLOCKED→STG_LOCKED after the lock interval with no step; STG_LOCKED→STG_UNLOCKED on any step. Basic: IDLE→PLUS1/MINUS1 on a first sign; PLUS1→IDLE with a down step on a second plus; MINUS1→IDLE with an up step on a second minus; an opposite sign moves PLUS1 and MINUS1 across to the other one-sign state. Refined: the same moves, except that a pair goes to HOLD_DN/HOLD_UP; a HOLD state goes to IDLE on the next sample, with a step unless that sample vetoes it.

Top module: `osc_steer_ctrl`

## Requirements
- R1: Each sample compares the cycle count between two successive reference rising edges with NOMINAL_CNT. A count above it is a plus error, a count below it is a minus error, and an equal count is zero. The first edge after reset, and the first edge after a holdover, only starts the count and produces no sample.
- R2: For the first WARMUP_PULSES samples after reset the DAC word stays at DAC_MID, locked_o is 0, and both digits read 0.
- R3: In the basic machine, a plus following a plus lowers the DAC word by one, and a minus following a minus raises it by one. An opposite sign replaces the remembered sign and causes no step.
- R4: Zero samples leave the remembered sign unchanged and never complete a pair.
- R5: The DAC word saturates at 0 and at 16383. A step beyond a limit leaves the word unchanged but still counts as an update.
- R6: locked_o rises on the LOCK_SECS-th sample after the last DAC update, or after the end of warm-up. Any DAC update clears locked_o and restarts this count.
- R7: Once locked_o is 1 and the DAC has at some time been both raised and lowered, the refined machine becomes active and stays active until reset.
- R8: In the refined machine a same-sign pair arms a pending step and leaves the DAC unchanged (digit 4 for a pending lower, 5 for a pending raise). If the next sample has the opposite sign, the step is discarded.
- R9: If the sample after an armed pair is zero or of the same sign, the pending step is applied.
- R10: If no reference edge arrives within 2*NOMINAL_CNT cycles of the previous one, holdover_o is set, the DAC word is frozen, and the pending step and pair history are cleared. holdover_o clears at the next sample.
- R11: basic_digit_o reads 1/2/3 for BS_IDLE/BS_PLUS1/BS_MINUS1 while the basic machine is active. refined_digit_o reads 1..5 for RS_IDLE, RS_PLUS1, RS_MINUS1, RS_HOLD_DN, RS_HOLD_UP while the refined machine is active. An inactive machine reads 0.
- R12: The DAC word changes by exactly one step, and only in the cycle after a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| ref_pulse_i | input | 1 | Asynchronous once-per-second reference pulse |
| dac_word_o | output | DAC_W (14) | DAC tuning word (higher raises frequency) |
| locked_o | output | 1 | Lock indication |
| holdover_o | output | 1 | Reference missing, DAC frozen |
| basic_digit_o | output | 3 | Basic machine state digit |
| refined_digit_o | output | 3 | Refined machine state digit |

## Verification
The hardest situation to reach is a vetoed pending step in the refined machine. Getting there needs warm-up to finish, steps in both directions, a full lock interval with no update, and then a pair followed by an opposite sign. The bench shrinks NOMINAL_CNT, the warm-up and the lock interval, and starts DAC_MID one below full scale so that the top limit is reached within two steps. It then shapes the spacing between reference pulses to walk the controller through exactly that sequence. A pending pair cut off by a missing pulse is reached in the same run.

// File: rtl/osc_steer_pkg.sv
package osc_steer_pkg;

    typedef enum logic [1:0] {
        ERR_ZERO  = 2'd0,
        ERR_PLUS  = 2'd1,
        ERR_MINUS = 2'd2
    } err_e;

    typedef enum logic [1:0] {
        STG_WARMUP   = 2'd0,
        STG_UNLOCKED = 2'd1,
        STG_LOCKED   = 2'd2
    } stage_e;

    typedef enum logic [1:0] {
        BS_IDLE   = 2'd0,
        BS_PLUS1  = 2'd1,
        BS_MINUS1 = 2'd2
    } basic_e;

    typedef enum logic [2:0] {
        RS_IDLE    = 3'd0,
        RS_PLUS1   = 3'd1,
        RS_MINUS1  = 3'd2,
        RS_HOLD_DN = 3'd3,
        RS_HOLD_UP = 3'd4
    } refined_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

endpackage

// File: rtl/osc_ref_sync.sv
module osc_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    // sync chain plus one history flop for edge detection
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC_STAGES-1:0], async_i};
        end
    end

    assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/osc_period_meter.sv
module osc_period_meter
    import osc_steer_pkg::*;
#(
    parameter int NOMINAL_CNT = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic smp_vld_o,
    output err_e smp_err_o,
    output logic miss_o
);

    localparam int CNT_W = $clog2(2 * NOMINAL_CNT + 1);
    localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOMINAL_CNT);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(2 * NOMINAL_CNT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            smp_vld_o <= 1'b0;
            smp_err_o <= ERR_ZERO;
            miss_o    <= 1'b0;
        end else begin
            smp_vld_o <= 1'b0;
            miss_o    <= 1'b0;
            if (edge_i) begin
                if (armed_q) begin
                    smp_vld_o <= 1'b1;
                    smp_err_o <= (cnt_q > NOM_C) ? ERR_PLUS :
                                 (cnt_q < NOM_C) ? ERR_MINUS : ERR_ZERO;
                end
                cnt_q   <= ONE_C;
                armed_q <= 1'b1;
            end else if (armed_q) begin
                if (cnt_q == LIM_C) begin
                    miss_o  <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + ONE_C;
                end
            end
        end
    end

endmodule

// File: rtl/osc_basic_steer.sv
module osc_basic_steer
    import osc_steer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active_i,
    input  logic        clear_i,
    input  logic        smp_vld_i,
    input  err_e        smp_err_i,
    output step_e       step_o,
    output logic [2:0]  digit_o
);

    basic_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        step_o = STEP_NONE;
        if (!active_i || clear_i) begin
            st_d = BS_IDLE;
        end else if (smp_vld_i) begin
            unique case (st_q)
                BS_IDLE: begin
                    if (smp_err_i == ERR_PLUS)       st_d = BS_PLUS1;
                    else if (smp_err_i == ERR_MINUS) st_d = BS_MINUS1;
                end
                BS_PLUS1: begin
                    if (smp_err_i == ERR_PLUS) begin
                        st_d   = BS_IDLE;
                        step_o = STEP_DN;
                    end else if (smp_err_i == ERR_MINUS) begin
                        st_d = BS_MINUS1;
                    end
                end
                BS_MINUS1: begin
                    if (smp_err_i == ERR_MINUS) begin
                        st_d   = BS_IDLE;
                        step_o = STEP_UP;
                    end else if (smp_err_i == ERR_PLUS) begin
                        st_d = BS_PLUS1;
                    end
                end
                default: st_d = BS_IDLE;
            endcase
        end
    end

    always_comb begin
        digit_o = active_i ? ({1'b0, st_q} + 3'd1) : 3'd0;
    end

endmodule

// File: rtl/osc_refined_steer.sv
module osc_refined_steer
    import osc_steer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active_i,
    input  logic        clear_i,
    input  logic        smp_vld_i,
    input  err_e        smp_err_i,
    output step_e       step_o,
    output logic [2:0]  digit_o
);

    refined_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        step_o = STEP_NONE;
        if (!active_i || clear_i) begin
            st_d = RS_IDLE;
        end else if (smp_vld_i) begin
            unique case (st_q)
                RS_IDLE: begin
                    if (smp_err_i == ERR_PLUS)       st_d = RS_PLUS1;
                    else if (smp_err_i == ERR_MINUS) st_d = RS_MINUS1;
                end
                RS_PLUS1: begin
                    if (smp_err_i == ERR_PLUS)       st_d = RS_HOLD_DN;
                    else if (smp_err_i == ERR_MINUS) st_d = RS_MINUS1;
                end
                RS_MINUS1: begin
                    if (smp_err_i == ERR_MINUS)     st_d = RS_HOLD_UP;
                    else if (smp_err_i == ERR_PLUS) st_d = RS_PLUS1;
                end
                RS_HOLD_DN: begin
                    st_d = RS_IDLE;
                    if (smp_err_i != ERR_MINUS) step_o = STEP_DN;
                end
                RS_HOLD_UP: begin
                    st_d = RS_IDLE;
                    if (smp_err_i != ERR_PLUS) step_o = STEP_UP;
                end
                default: st_d = RS_IDLE;
            endcase
        end
    end

    always_comb begin
        digit_o = active_i ? (st_q + 3'd1) : 3'd0;
    end

endmodule

// File: rtl/osc_steer_ctrl.sv
module osc_steer_ctrl
    import osc_steer_pkg::*;
#(
    parameter int NOMINAL_CNT   = 10_000_000,
    parameter int DAC_W         = 14,
    parameter int DAC_MID       = 8192,
    parameter int WARMUP_PULSES = 600,
    parameter int LOCK_SECS     = 96,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse_i,
    output logic [DAC_W-1:0] dac_word_o,
    output logic             locked_o,
    output logic             holdover_o,
    output logic [2:0]       basic_digit_o,
    output logic [2:0]       refined_digit_o
);

    localparam int WRM_W = $clog2(WARMUP_PULSES + 1);
    localparam int LCK_W = $clog2(LOCK_SECS + 1);
    localparam logic [DAC_W-1:0] DAC_MAX  = '1;
    localparam logic [DAC_W-1:0] DAC_MIN  = '0;
    localparam logic [DAC_W-1:0] DAC_RST  = DAC_W'(DAC_MID);
    localparam logic [DAC_W-1:0] DAC_ONE  = DAC_W'(1);
    localparam logic [WRM_W-1:0] WRM_LAST = WRM_W'(WARMUP_PULSES - 1);
    localparam logic [LCK_W-1:0] LCK_LAST = LCK_W'(LOCK_SECS - 1);

    logic             ref_rise;
    logic             smp_vld;
    err_e             smp_err;
    logic             miss;
    step_e            b_step, r_step, step;
    logic             basic_act;
    stage_e           stage_q, stage_d;
    logic [WRM_W-1:0] warm_cnt_q;
    logic [LCK_W-1:0] lock_cnt_q;
    logic [DAC_W-1:0] dac_q;
    logic             seen_up_q, seen_dn_q, refined_q, hold_q;

    osc_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_pulse_i),
        .rise_o  (ref_rise)
    );

    osc_period_meter #(.NOMINAL_CNT(NOMINAL_CNT)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (ref_rise),
        .smp_vld_o (smp_vld),
        .smp_err_o (smp_err),
        .miss_o    (miss)
    );

    assign basic_act = (stage_q != STG_WARMUP) && !refined_q;

    osc_basic_steer u_basic (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (basic_act),
        .clear_i   (miss),
        .smp_vld_i (smp_vld),
        .smp_err_i (smp_err),
        .step_o    (b_step),
        .digit_o   (basic_digit_o)
    );

    osc_refined_steer u_refined (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (refined_q),
        .clear_i   (miss),
        .smp_vld_i (smp_vld),
        .smp_err_i (smp_err),
        .step_o    (r_step),
        .digit_o   (refined_digit_o)
    );

    assign step = refined_q ? r_step : b_step;

    // stage transitions
    always_comb begin
        stage_d = stage_q;
        unique case (stage_q)
            STG_WARMUP: begin
                if (smp_vld && warm_cnt_q == WRM_LAST) stage_d = STG_UNLOCKED;
            end
            STG_UNLOCKED: begin
                if (step == STEP_NONE && smp_vld && lock_cnt_q == LCK_LAST)
                    stage_d = STG_LOCKED;
            end
            STG_LOCKED: begin
                if (step != STEP_NONE) stage_d = STG_UNLOCKED;
            end
            default: stage_d = STG_WARMUP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= STG_WARMUP;
        end else begin
            stage_q <= stage_d;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_cnt_q <= '0;
            lock_cnt_q <= '0;
            dac_q      <= DAC_RST;
            seen_up_q  <= 1'b0;
            seen_dn_q  <= 1'b0;
            refined_q  <= 1'b0;
            hold_q     <= 1'b0;
        end else begin
            if (smp_vld && stage_q == STG_WARMUP)
                warm_cnt_q <= warm_cnt_q + WRM_W'(1);

            if (step != STEP_NONE || stage_q == STG_WARMUP)
                lock_cnt_q <= '0;
            else if (smp_vld && stage_q == STG_UNLOCKED)
                lock_cnt_q <= lock_cnt_q + LCK_W'(1);

            unique case (step)
                STEP_UP: begin
                    dac_q     <= (dac_q == DAC_MAX) ? DAC_MAX : dac_q + DAC_ONE;
                    seen_up_q <= 1'b1;
                end
                STEP_DN: begin
                    dac_q     <= (dac_q == DAC_MIN) ? DAC_MIN : dac_q - DAC_ONE;
                    seen_dn_q <= 1'b1;
                end
                default: ;
            endcase

            if (stage_q == STG_LOCKED && seen_up_q && seen_dn_q)
                refined_q <= 1'b1;

            if (miss)
                hold_q <= 1'b1;
            else if (smp_vld)
                hold_q <= 1'b0;
        end
    end

    assign dac_word_o = dac_q;
    assign locked_o   = (stage_q == STG_LOCKED);
    assign holdover_o = hold_q;

endmodule

// File: rtl/osc_steer_chk.sv
module osc_steer_chk
    import osc_steer_pkg::*;
#(
    parameter int DAC_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DAC_W-1:0] dac_word,
    input logic             locked,
    input logic             holdover,
    input logic [2:0]       basic_digit,
    input logic [2:0]       refined_digit,
    input logic             smp_vld,
    input logic             miss,
    input stage_e           stage
);

    localparam logic [DAC_W-1:0] ONE = DAC_W'(1);

    p_unit_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |->
            (dac_word == $past(dac_word) + ONE || dac_word == $past(dac_word) - ONE));

    p_step_after_sample_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> $past(smp_vld));

    p_update_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_word) |-> !locked);

    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (holdover && $past(holdover)) |-> $stable(dac_word));

    p_miss_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (basic_digit <= 3'd1 && refined_digit <= 3'd1));

    p_one_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(basic_digit != 3'd0 && refined_digit != 3'd0));

    p_warm_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == STG_WARMUP) |-> (basic_digit == 3'd0 && refined_digit == 3'd0 && !locked));

    p_refined_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (refined_digit != 3'd0) |=> (refined_digit != 3'd0));

endmodule

bind osc_steer_ctrl osc_steer_chk #(.DAC_W(DAC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dac_word      (dac_word_o),
    .locked        (locked_o),
    .holdover      (holdover_o),
    .basic_digit   (basic_digit_o),
    .refined_digit (refined_digit_o),
    .smp_vld       (smp_vld),
    .miss          (miss),
    .stage         (stage_q)
);

// File: tb/osc_steer_ctrl_tb.sv
`timescale 1ns/1ps
module osc_steer_ctrl_tb;

    localparam int NOM   = 20;
    localparam int MID   = 16382;
    localparam int WARM  = 3;
    localparam int LOCKN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_pulse = 1'b0;
    logic [13:0] dac;
    logic        locked, hold;
    logic [2:0]  bdig, rdig;

    always #2.5 clk = ~clk;

    osc_steer_ctrl #(
        .NOMINAL_CNT(NOM), .DAC_W(14), .DAC_MID(MID),
        .WARMUP_PULSES(WARM), .LOCK_SECS(LOCKN), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_pulse),
        .dac_word_o(dac), .locked_o(locked), .holdover_o(hold),
        .basic_digit_o(bdig), .refined_digit_o(rdig)
    );

    typedef struct {
        int    dac;
        bit    lk;
        bit    ho;
        int    bd;
        int    rd;
        string req;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit driver_done = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int m_dac = MID;
    int m_stage = 0;
    int m_warm = 0;
    int m_lock = 0;
    bit m_up = 0, m_dn = 0, m_refm = 0, m_hold = 0;
    int m_b = 0;
    int m_r = 0;

    task automatic model_sample(input int e);
        int st;
        bit was_warm;
        st = 0;
        was_warm = (m_stage == 0);
        m_hold = 0;
        if (was_warm) begin
            m_warm++;
            if (m_warm == WARM) begin m_stage = 1; m_lock = 0; end
        end else if (m_refm) begin
            case (m_r)
                0: if (e > 0) m_r = 1; else if (e < 0) m_r = 2;
                1: if (e > 0) m_r = 3; else if (e < 0) m_r = 2;
                2: if (e < 0) m_r = 4; else if (e > 0) m_r = 1;
                3: begin if (e >= 0) st = -1; m_r = 0; end
                default: begin if (e <= 0) st = 1; m_r = 0; end
            endcase
        end else begin
            case (m_b)
                0: if (e > 0) m_b = 1; else if (e < 0) m_b = 2;
                1: if (e > 0) begin st = -1; m_b = 0; end else if (e < 0) m_b = 2;
                default: if (e < 0) begin st = 1; m_b = 0; end else if (e > 0) m_b = 1;
            endcase
        end
        if (st != 0) begin
            if (st > 0) begin m_up = 1; if (m_dac < 16383) m_dac++; end
            else begin m_dn = 1; if (m_dac > 0) m_dac--; end
            m_stage = 1;
            m_lock = 0;
        end else if (!was_warm && m_stage == 1) begin
            m_lock++;
            if (m_lock == LOCKN) m_stage = 2;
        end
        if (m_stage == 2 && m_up && m_dn && !m_refm) begin
            m_refm = 1;
            m_b = 0;
        end
    endtask

    task automatic push_exp(input string req);
        exp_t x;
        x.dac = m_dac;
        x.lk  = (m_stage == 2);
        x.ho  = m_hold;
        x.bd  = (m_stage != 0 && !m_refm) ? m_b + 1 : 0;
        x.rd  = m_refm ? m_r + 1 : 0;
        x.req = req;
        q.push_back(x);
    endtask

    task automatic pulse();
        @(negedge clk) ref_pulse = 1'b1;
        repeat (2) @(negedge clk);
        ref_pulse = 1'b0;
    endtask

    // one reference second whose rising edge is gap cycles after the previous one
    task automatic sec(input int gap, input string req);
        repeat (gap - 3) @(negedge clk);
        pulse();
        model_sample((gap > NOM) ? 1 : (gap < NOM) ? -1 : 0);
        push_exp(req);
    endtask

    task automatic lose_ref(input string req);
        repeat (2 * NOM + 6) @(negedge clk);
        m_hold = 1; m_b = 0; m_r = 0;
        push_exp(req);
    endtask

    // monitor: compare design outputs with queued expectations
    initial begin
        exp_t x;
        forever begin
            wait (q.size() > 0);
            repeat (6) @(negedge clk);
            x = q.pop_front();
            total++;
            if (int'(dac) != x.dac || locked != x.lk || hold != x.ho ||
                int'(bdig) != x.bd || int'(rdig) != x.rd) begin
                bad++;
                $display("FAIL %s: got dac=%0d lk=%0b ho=%0b bd=%0d rd=%0d exp dac=%0d lk=%0b ho=%0b bd=%0d rd=%0d",
                         x.req, dac, locked, hold, bdig, rdig, x.dac, x.lk, x.ho, x.bd, x.rd);
            end
        end
    end

    // driver
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        push_exp("R2 reset state");
        repeat (8) @(negedge clk);
        pulse();
        push_exp("R1 first edge only arms");
        // warm-up, plus counts ignored
        sec(21, "R2 warm-up hold 1");
        sec(21, "R2 warm-up hold 2");
        sec(21, "R2 warm-up end");
        // basic minus pair raises, then saturation at full scale
        sec(19, "R1 minus count R11 digit");
        sec(19, "R3 minus pair raises");
        sec(19, "R3 first minus");
        sec(19, "R5 saturate at top");
        // zero skip inside a plus pair
        sec(21, "R1 plus count");
        sec(20, "R4 zero keeps sign");
        sec(21, "R4 pair across zero lowers R12");
        // opposite sign replaces history, then quiet until lock
        sec(21, "R3 plus remembered");
        sec(19, "R3 opposite replaces");
        sec(20, "R6 zero counts toward lock");
        sec(20, "R6 R7 lock and refined entry");
        // refined veto
        sec(21, "R8 refined first plus");
        sec(21, "R8 pair arms pending");
        sec(19, "R8 opposite vetoes");
        // refined apply on zero
        sec(21, "R9 first plus");
        sec(21, "R9 arm");
        sec(20, "R9 zero applies R6 unlock");
        // refined apply on same sign
        sec(19, "R9 minus");
        sec(19, "R9 arm up");
        sec(19, "R9 same sign applies");
        // pending cleared by missing reference
        sec(21, "R10 plus");
        sec(21, "R10 arm before loss");
        lose_ref("R10 holdover set");
        pulse();
        push_exp("R10 R1 restart edge no sample");
        sec(19, "R10 holdover cleared, history gone");
        driver_done = 1'b1;
    end

    // completion
    initial begin
        wait (driver_done && q.size() == 0);
        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule